// File: doc/BRIEF.md
# Slot-Mapped 48-Bit Tick Timer

This block is a free-running tick counter that sits in one slot of a simple memory-mapped I/O bus. The slot presents a word address, a write data word, a read data word, and read, write and chip-select strobes. Software starts and stops the count by writing a run enable into a control word. In the same control word it can request a clear, which zeroes the count for exactly one clock and is never stored.

The count is wider than a bus word, so software fetches it as two reads: a lower word holding the least significant bits and an upper word holding the remaining bits right-aligned, with zeros above them. Read data is a purely combinational function of the address. Only the two least significant address bits take part in decoding, so higher address bits alias onto the same four words.

Top module: `slot_tick_timer`

## Requirements
- R1: A synchronous, active-high reset sets the count to 0 and the run enable to 0, so the count stays at 0 after reset until software starts it.
- R2: While the run enable is 1, the count increases by exactly one on every clock edge and wraps to 0 after reaching 2^CNT_W - 1.
- R3: While the run enable is 0 and no clear is requested, the count holds its value.
- R4: A write with chip select high and address bits [1:0] equal to 2 (the control word) loads write data bit 0 into the run enable at that clock edge. Writes to any other word, and writes with chip select low, leave the run enable unchanged.
- R5: A control-word write with write data bit 1 set makes the count 0 at that clock edge, taking priority over an increment. The clear request is not held: if the run enable is 1, counting resumes from 0 on the following edge.
- R6: A control-word write with data bits [1:0] equal to 3 leaves the count at 0 and running, so the run enable is unaffected by the clear bit.
- R7: Address bits [1:0] equal to 0 return count bits DATA_W-1 down to 0.
- R8: Address bits [1:0] equal to 1 return count bits CNT_W-1 down to DATA_W in read data bits CNT_W-DATA_W-1 down to 0; all higher read data bits are 0.
- R9: Address bits [1:0] equal to 2 or 3 return 0.
- R10: Read data depends only on the address and the count, not on the read strobe or chip select, and address bits above bit 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Chip select for this slot |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read data does not depend on it) |
| bus_addr | input | ADDR_W | Word address within the slot |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |

## Verification
On every cycle, the assertions check the counter's step rule, covering increment, hold, clear priority and reset. They also check the run enable's load and hold behaviour on control and non-control writes, and the shape of each read word against the live count, including the zero padding of the upper word and the zero words. Only the bench scenarios can show the behaviours that need a sequence of stimuli. These are that the clear is not remembered and counting resumes the next cycle, that a combined clear and start leaves the timer running from 0, that higher address bits alias, and that the upper word carries correctly and the count wraps. The bench shows the last two on a narrow second instance whose count can be driven past a word boundary and through its full range within the run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Word offsets within the slot, decoded from address bits [1:0]
   typedef enum logic [1:0] {
      WORD_CNT_LO = 2'd0,
      WORD_CNT_HI = 2'd1,
      WORD_CTRL   = 2'd2,
      WORD_SPARE  = 2'd3
   } slot_word_e;

   localparam int unsigned WORD_SEL_W = 2;

   // Number of segments needed to cover a width with a segment size
   function automatic int unsigned seg_count(input int unsigned width, input int unsigned seg);
      return (width + seg - 1) / seg;
   endfunction

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
   import tmr_pkg::*;
#(
   parameter int unsigned RUN_BIT = 0,
   parameter int unsigned CLR_BIT = 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  sel,
   input  logic                  wr,
   input  logic [WORD_SEL_W-1:0] word,
   input  logic                  run_req,
   input  logic                  clr_req,
   output logic                  run_q,
   output logic                  clr_pulse
);

   logic ctrl_hit;

   // Control word write decode: only the low address bits take part
   assign ctrl_hit = sel & wr & (slot_word_e'(word) == WORD_CTRL);

   // Run enable is latched state
   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
      end else if (ctrl_hit) begin
         run_q <= run_req;
      end
   end

   // Clear lasts only as long as the single write cycle
   assign clr_pulse = ctrl_hit & clr_req;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 48,
   parameter int unsigned SEG_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_en,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   localparam int unsigned NSEG = seg_count(CNT_W, SEG_W);

   generate
      if (SEG_W >= CNT_W) begin : g_flat
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst || clr) begin
               cnt_q <= '0;
            end else if (inc_en) begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end

         assign cnt = cnt_q;
      end else begin : g_seg
         logic [NSEG-1:0] carry;

         assign carry[0] = inc_en;

         for (genvar s = 0; s < NSEG; s++) begin : g_part
            localparam int unsigned LO = s * SEG_W;
            localparam int unsigned W  = ((CNT_W - LO) < SEG_W) ? (CNT_W - LO) : SEG_W;

            logic [W-1:0] part_q;

            always_ff @(posedge clk) begin
               if (rst || clr) begin
                  part_q <= '0;
               end else if (carry[s]) begin
                  part_q <= part_q + W'(1);
               end
            end

            // Ripple enable into the next segment when this one is all ones
            if (s < NSEG - 1) begin : g_carry
               assign carry[s+1] = carry[s] & (&part_q);
            end

            assign cnt[LO+W-1:LO] = part_q;
         end
      end
   endgenerate

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 48,
   parameter int unsigned DATA_W = 32
) (
   input  logic [WORD_SEL_W-1:0] word,
   input  logic [CNT_W-1:0]      cnt,
   output logic [DATA_W-1:0]     rdata
);

   localparam int unsigned HI_W  = CNT_W - DATA_W;
   localparam int unsigned PAD_W = DATA_W - HI_W;

   logic [DATA_W-1:0] lo_word;
   logic [DATA_W-1:0] hi_word;

   assign lo_word = cnt[DATA_W-1:0];

   generate
      if (PAD_W == 0) begin : g_full_hi
         assign hi_word = cnt[CNT_W-1:DATA_W];
      end else begin : g_pad_hi
         assign hi_word = {{PAD_W{1'b0}}, cnt[CNT_W-1:DATA_W]};
      end
   endgenerate

   always_comb begin
      unique case (slot_word_e'(word))
         WORD_CNT_LO: rdata = lo_word;
         WORD_CNT_HI: rdata = hi_word;
         default:     rdata = '0;
      endcase
   end

endmodule

// File: rtl/slot_tick_timer.sv
module slot_tick_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W   = 48,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned SEG_W   = 16,
   parameter int unsigned RUN_BIT = 0,
   parameter int unsigned CLR_BIT = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   // Elaboration-time parameter checks
   generate
      if (CNT_W <= DATA_W) begin : g_bad_cnt_narrow
         $error("slot_tick_timer: CNT_W must exceed DATA_W");
      end
      if (CNT_W > 2 * DATA_W) begin : g_bad_cnt_wide
         $error("slot_tick_timer: CNT_W must fit in two data words");
      end
      if (ADDR_W < WORD_SEL_W) begin : g_bad_addr
         $error("slot_tick_timer: ADDR_W must be at least 2");
      end
      if (RUN_BIT == CLR_BIT || RUN_BIT >= DATA_W || CLR_BIT >= DATA_W) begin : g_bad_bits
         $error("slot_tick_timer: control bit positions invalid");
      end
      if (SEG_W == 0) begin : g_bad_seg
         $error("slot_tick_timer: SEG_W must be nonzero");
      end
   endgenerate

   logic [WORD_SEL_W-1:0] word_sel;
   logic                  go_q;
   logic                  clr_pulse;
   logic [CNT_W-1:0]      cnt_q;
   logic                  unused_ok;

   assign word_sel  = bus_addr[WORD_SEL_W-1:0];
   // Read strobe, upper address and spare data bits take no part in the function
   assign unused_ok = ^{bus_rd, bus_addr, bus_wdata};

   tmr_ctrl #(
      .RUN_BIT (RUN_BIT),
      .CLR_BIT (CLR_BIT)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .sel       (bus_sel),
      .wr        (bus_wr),
      .word      (word_sel),
      .run_req   (bus_wdata[RUN_BIT]),
      .clr_req   (bus_wdata[CLR_BIT]),
      .run_q     (go_q),
      .clr_pulse (clr_pulse)
   );

   tmr_counter #(
      .CNT_W (CNT_W),
      .SEG_W (SEG_W)
   ) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .inc_en (go_q),
      .clr    (clr_pulse),
      .cnt    (cnt_q)
   );

   tmr_rdmux #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_rdmux (
      .word  (word_sel),
      .cnt   (cnt_q),
      .rdata (bus_rdata)
   );

endmodule

// File: rtl/slot_tick_timer_chk.sv
module slot_tick_timer_chk #(
   parameter int unsigned CNT_W   = 48,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned RUN_BIT = 0,
   parameter int unsigned CLR_BIT = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              sel,
   input logic              wr,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [CNT_W-1:0]  cnt,
   input logic              run
);

   logic ctl_wr;
   logic clr_wr;

   assign ctl_wr = sel && wr && (addr[1:0] == 2'd2);
   assign clr_wr = ctl_wr && wdata[CLR_BIT];

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (cnt == '0 && !run));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr_wr && run) |=> (cnt == $past(cnt) + 1'b1));

   // R3
   count_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr_wr && !run) |=> $stable(cnt));

   // R4
   run_load_chk: assert property (@(posedge clk) disable iff (rst)
      ctl_wr |=> (run == $past(wdata[RUN_BIT])));

   // R4
   run_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !ctl_wr |=> $stable(run));

   // R5
   clear_prio_chk: assert property (@(posedge clk) disable iff (rst)
      clr_wr |=> (cnt == '0));

   // R7
   lo_word_chk: assert property (@(posedge clk) disable iff (rst)
      (addr[1:0] == 2'd0) |-> (rdata == cnt[DATA_W-1:0]));

   // R8
   hi_word_chk: assert property (@(posedge clk) disable iff (rst)
      (addr[1:0] == 2'd1) |-> (rdata == DATA_W'(cnt >> DATA_W)));

   // R9
   zero_word_chk: assert property (@(posedge clk) disable iff (rst)
      (addr[1] == 1'b1) |-> (rdata == '0));

endmodule

bind slot_tick_timer slot_tick_timer_chk #(
   .CNT_W   (CNT_W),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .RUN_BIT (RUN_BIT),
   .CLR_BIT (CLR_BIT)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .sel   (bus_sel),
   .wr    (bus_wr),
   .addr  (bus_addr),
   .wdata (bus_wdata),
   .rdata (bus_rdata),
   .cnt   (cnt_q),
   .run   (go_q)
);

// File: tb/tb_slot_tick_timer.sv
module tb_slot_tick_timer;

   localparam int unsigned NCNT = 12;
   localparam int unsigned NDAT = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_w;
   logic [7:0]  rdata_n;

   int checks = 0;
   int errors = 0;
   logic mon_en = 1'b0;
   logic done = 1'b0;

   // Reference state kept from the requirements
   logic [47:0] m_cnt = '0;
   logic        m_go = 1'b0;

   typedef struct {
      logic [31:0] exp_w;
      logic [7:0]  exp_n;
      string       tag;
   } sb_item_t;

   sb_item_t sb[$];

   always #10 clk = ~clk;

   slot_tick_timer dut (
      .clk (clk), .rst (rst), .bus_sel (bus_sel), .bus_wr (bus_wr),
      .bus_rd (bus_rd), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_rdata (rdata_w)
   );

   // Narrow instance: carries into the upper word and wraps within the run
   slot_tick_timer #(.CNT_W(NCNT), .DATA_W(NDAT), .SEG_W(5)) dut_nar (
      .clk (clk), .rst (rst), .bus_sel (bus_sel), .bus_wr (bus_wr),
      .bus_rd (bus_rd), .bus_addr (bus_addr), .bus_wdata (bus_wdata[7:0]),
      .bus_rdata (rdata_n)
   );

   // Model: control word at address bits [1:0]==2, bit 0 run, bit 1 clear
   always @(posedge clk) begin
      if (rst) begin
         m_cnt <= '0;
         m_go  <= 1'b0;
      end else begin
         if (bus_sel && bus_wr && bus_addr[1:0] == 2'd2) m_go <= bus_wdata[0];
         if (bus_sel && bus_wr && bus_addr[1:0] == 2'd2 && bus_wdata[1]) m_cnt <= '0;
         else if (m_go) m_cnt <= m_cnt + 48'd1;
      end
   end

   function automatic logic [31:0] exp_wide(input logic [4:0] a);
      case (a[1:0])
         2'd0:    return m_cnt[31:0];
         2'd1:    return {16'h0, m_cnt[47:32]};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [7:0] exp_narrow(input logic [4:0] a);
      case (a[1:0])
         2'd0:    return m_cnt[7:0];
         2'd1:    return {4'h0, m_cnt[11:8]};
         default: return 8'h0;
      endcase
   endfunction

   // Driver: one bus write
   task automatic bus_write(input logic sel, input logic [4:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   // Driver: present an address and push the expected words
   task automatic bus_read(input logic [4:0] a, input logic strobe, input string tag);
      sb_item_t it;
      @(posedge clk); #1;
      bus_sel = strobe; bus_rd = strobe; bus_addr = a;
      it.exp_w = exp_wide(a);
      it.exp_n = exp_narrow(a);
      it.tag   = tag;
      sb.push_back(it);
      mon_en = 1'b1;
      @(posedge clk); #1;
      mon_en = 1'b0; bus_sel = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   // Monitor: compare away from the active edge
   always @(negedge clk) begin
      if (mon_en && sb.size() > 0) begin
         sb_item_t it;
         it = sb.pop_front();
         checks++;
         if (rdata_w !== it.exp_w) begin
            errors++;
            $display("FAIL %s (wide): actual %h expected %h", it.tag, rdata_w, it.exp_w);
         end
         checks++;
         if (rdata_n !== it.exp_n) begin
            errors++;
            $display("FAIL %s (narrow): actual %h expected %h", it.tag, rdata_n, it.exp_n);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      bus_read(5'd0, 1'b1, "R1 reset lower word");
      bus_read(5'd1, 1'b1, "R1 R8 reset upper word");
      bus_read(5'd2, 1'b1, "R9 control word reads zero");
      idle(5);
      bus_read(5'd0, 1'b1, "R3 idle after reset holds");

      bus_write(1'b1, 5'd2, 32'h1);
      idle(10);
      bus_read(5'd0, 1'b1, "R2 counting lower word");
      bus_read(5'd1, 1'b1, "R8 upper word while small");

      bus_write(1'b1, 5'd0, 32'h0);
      bus_read(5'd0, 1'b1, "R4 write to lower word ignored");
      bus_write(1'b0, 5'd2, 32'h0);
      bus_read(5'd0, 1'b1, "R4 write without select ignored");
      bus_write(1'b1, 5'd3, 32'h2);
      bus_read(5'd0, 1'b1, "R4 write to spare word ignored");

      bus_write(1'b1, 5'd2, 32'h0);
      bus_read(5'd0, 1'b1, "R3 paused value");
      idle(6);
      bus_read(5'd0, 1'b1, "R3 paused value holds");

      bus_write(1'b1, 5'd2, 32'h2);
      bus_read(5'd0, 1'b1, "R5 clear while paused");
      idle(4);
      bus_read(5'd0, 1'b1, "R5 clear not stored, run stays off");

      bus_write(1'b1, 5'd2, 32'h3);
      bus_read(5'd0, 1'b1, "R6 clear with start");
      idle(7);
      bus_read(5'd0, 1'b1, "R6 running after clear with start");

      idle(20);
      bus_write(1'b1, 5'd2, 32'h3);
      bus_read(5'd0, 1'b1, "R5 clear beats increment");
      bus_read(5'd0, 1'b1, "R5 counting resumes after clear");

      idle(300);
      bus_read(5'd1, 1'b1, "R8 upper word after carry");
      bus_read(5'd0, 1'b1, "R7 lower word after carry");
      idle(4100);
      bus_read(5'd0, 1'b1, "R2 narrow count after wrap");
      bus_read(5'd1, 1'b1, "R2 R8 upper after wrap");

      bus_read(5'd0, 1'b0, "R10 read data without strobe");
      bus_read(5'd5, 1'b1, "R10 high address bits alias upper word");
      bus_read(5'd4, 1'b0, "R10 alias lower word without strobe");
      bus_read(5'd3, 1'b1, "R9 spare word reads zero");
      bus_read(5'd6, 1'b1, "R9 R10 aliased control reads zero");

      idle(2);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule